// File: doc/BRIEF.md
# Digital Voltage Loop with Soft-Start

This block closes the outer, slow loop of a boost power-factor-correction controller. Each time a new output-voltage sample arrives from the sigma-delta front end (nominally 3.55 kHz), the sample passes through a programmable second-order notch. The notch strips out the ripple at twice the line frequency. The filtered value is then compared with a reference code that stands for the 2.5 V feedback set point. A proportional-integral stage turns the error into an unsigned current-amplitude word, which a DAC outside this block converts to the analog level that scales the inner current loop.

At start-up the command word does not come from the PI stage. It follows a linear ramp: the first update places it at a programmable starting level plus one step, and each later update adds one more step. The input current therefore rises from zero in a controlled way. When a filtered sample first reaches 95% of the reference, the ramp is released and the PI stage takes over, with its integrator seeded at the ramp level so that the command does not jump. The ready flag is raised at that point. The flag stays set until reset, or until the sequencer drops the enable input and so leaves normal operation.

Top module: `vloop_top`

## Requirements
- R1: While reset is asserted, and while `enable` is low after reset, `cmd` is 0 and `ready` is 0.
- R2: Only a cycle with `smp_stb` high starts a loop update. Its effect appears on `cmd` and `ready` after exactly two rising edges. Between updates, `cmd` does not change.
- R3: The notch computes y = sat16((b0·x + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]) >>> 14). Coefficients are signed with 14 fraction bits, the shift rounds toward minus infinity, and the result saturates to the signed 16-bit range.
- R4: The hand-over threshold is thr = (vref·973) >>> 10, about 95% of `vref`. A filtered sample equal to thr counts as reached, and one code below it does not.
- R5: Before ready, each update sets cmd = min(base + `ss_step`, 4095). The base is `ss_init` on the first update after reset or enable, and the previous ramp value on later updates.
- R6: The first update whose filtered sample is at or above thr sets `ready`. The same update already outputs the PI result, computed with the integrator starting from the last ramp level times 256.
- R7: Once ready, with e = vref − y: integ = clamp(integ + ki·e, 0, 4095·256) and cmd = clamp((integ + kp·e) >>> 8, 0, 4095). The gains are unsigned with 8 fraction bits.
- R8: Once set, `ready` stays high for any later sample value, including values below thr, while `enable` stays high.
- R9: Pulling `enable` low clears the notch history, the integrator, the ramp, `cmd` and `ready` at the next edge. The next update then starts the ramp again from `ss_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High while the sequencer is in normal operation |
| smp_stb | input | 1 | One-cycle strobe marking a new voltage sample |
| smp_val | input | 16 | Signed voltage sample code |
| vref | input | 16 | Signed reference code (2.5 V equivalent) |
| cf_b0 | input | 16 | Notch feed-forward coefficient, current sample |
| cf_b1 | input | 16 | Notch feed-forward coefficient, one sample back |
| cf_b2 | input | 16 | Notch feed-forward coefficient, two samples back |
| cf_a1 | input | 16 | Notch feedback coefficient, one output back |
| cf_a2 | input | 16 | Notch feedback coefficient, two outputs back |
| kp | input | 16 | Proportional gain, 8 fraction bits |
| ki | input | 16 | Integral gain, 8 fraction bits |
| ss_init | input | 12 | Soft-start starting level |
| ss_step | input | 12 | Soft-start increment per update |
| cmd | output | 12 | Current-amplitude command word |
| ready | output | 1 | Soft-start complete, PI in control |

## Verification
A strobe that is high before rising edge k loads the notch registers at edge k. The resulting `cmd` and `ready` values appear at edge k+1, so they are due at the falling edge after k+1. Between the two edges the old command must still be present. The bench keeps a behavioural model that delays each filtered sample by one edge before applying the PI or ramp step. The model and the design are compared at every falling edge, where none of their values is changing. Directed checks at the same falling edges cover the one-code threshold boundary, the seeded hand-over value, the integrator and output clamps, the sticky flag and the restart after a disable.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
    // number of biquad taps: b0, b1, b2 on inputs, a1, a2 on outputs
    localparam int NTAP = 5;
    // 95% threshold as a ratio NUM / 2**SH
    localparam logic [9:0] TH_NUM  = 10'd973;
    localparam int         TH_SH   = 10;
    localparam int         TH_BITS = 11;
endpackage

// File: rtl/vloop_biquad.sv
module vloop_biquad #(
    parameter int DW  = 16,
    parameter int CFW = 16,
    parameter int CFF = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  in_stb,
    input  logic signed [DW-1:0]  in_x,
    input  logic signed [CFW-1:0] c_b0,
    input  logic signed [CFW-1:0] c_b1,
    input  logic signed [CFW-1:0] c_b2,
    input  logic signed [CFW-1:0] c_a1,
    input  logic signed [CFW-1:0] c_a2,
    output logic                  out_vld,
    output logic signed [DW-1:0]  out_y
);
    localparam int NT = vloop_pkg::NTAP;
    localparam int AW = DW + CFW + 4;
    localparam logic signed [AW-1:0] YMAX = (AW'(1) <<< (DW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] YMIN = -(AW'(1) <<< (DW - 1));

    typedef struct packed {
        logic signed [DW-1:0] x1;
        logic signed [DW-1:0] x2;
        logic signed [DW-1:0] y1;
        logic signed [DW-1:0] y2;
        logic                 vld;
    } bq_st_t;

    bq_st_t s_d, s_q;

    logic signed [CFW-1:0] coef [NT];
    logic signed [DW-1:0]  tap  [NT];
    logic signed [AW-1:0]  prod [NT];
    logic signed [AW-1:0]  acc_d;
    logic signed [DW-1:0]  ysat_d;

    function automatic logic signed [DW-1:0] sat_out(input logic signed [AW-1:0] v);
        if (v > YMAX)      return {1'b0, {(DW-1){1'b1}}};
        else if (v < YMIN) return {1'b1, {(DW-1){1'b0}}};
        else               return v[DW-1:0];
    endfunction

    always_comb begin
        coef[0] = c_b0;  tap[0] = in_x;
        coef[1] = c_b1;  tap[1] = s_q.x1;
        coef[2] = c_b2;  tap[2] = s_q.x2;
        coef[3] = c_a1;  tap[3] = s_q.y1;
        coef[4] = c_a2;  tap[4] = s_q.y2;
    end

    for (genvar gi = 0; gi < NT; gi++) begin : g_tap
        assign prod[gi] = AW'(coef[gi]) * AW'(tap[gi]);
    end

    always_comb begin
        acc_d  = prod[0] + prod[1] + prod[2] - prod[3] - prod[4];
        ysat_d = sat_out(acc_d >>> CFF);
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!en) begin
            s_d = '0;
        end else if (in_stb) begin
            s_d.x1  = in_x;
            s_d.x2  = s_q.x1;
            s_d.y1  = ysat_d;
            s_d.y2  = s_q.y1;
            s_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_vld = s_q.vld;
    assign out_y   = s_q.y1;

    // R2: a filtered result is produced exactly one edge after each strobe
    a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_stb) |=> out_vld);
    a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb |=> !out_vld);
    // R3: without a strobe the filter history is frozen
    a_r3_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !in_stb) |=> $stable(out_y));
    // R9: disabling clears the filter history
    a_r9_hist_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_y == '0));
endmodule

// File: rtl/vloop_pi_ss.sv
module vloop_pi_ss #(
    parameter int DW = 16,
    parameter int GW = 16,
    parameter int CW = 12,
    parameter int GF = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 upd,
    input  logic signed [DW-1:0] y_in,
    input  logic signed [DW-1:0] vref,
    input  logic signed [DW-1:0] thr,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    input  logic [CW-1:0]        ss_init,
    input  logic [CW-1:0]        ss_step,
    output logic [CW-1:0]        cmd,
    output logic                 ready
);
    localparam int SW = DW + GW + CW + GF + 4;
    localparam logic signed [SW-1:0] CMAX_S = (SW'(1) <<< CW) - SW'(1);
    localparam logic signed [SW-1:0] IMAX_S = CMAX_S <<< GF;

    typedef struct packed {
        logic                 run;
        logic                 rdy;
        logic [CW-1:0]        ramp;
        logic [CW-1:0]        cmd;
        logic signed [SW-1:0] integ;
    } pi_st_t;

    pi_st_t s_d, s_q;

    logic signed [SW-1:0] err_d, pterm_d, iterm_d, ibase_d, isum_d, iclp_d, usum_d;
    logic [CW-1:0]        rbase_d, rnext_d, uclp_d;
    logic [CW:0]          rsum_d;
    logic                 cross_d;

    function automatic logic signed [SW-1:0] clamp_int(input logic signed [SW-1:0] v);
        if (v[SW-1])        return '0;
        else if (v > IMAX_S) return IMAX_S;
        else                return v;
    endfunction

    function automatic logic [CW-1:0] clamp_cmd(input logic signed [SW-1:0] v);
        if (v[SW-1])        return '0;
        else if (v > CMAX_S) return '1;
        else                return v[CW-1:0];
    endfunction

    always_comb begin
        err_d   = SW'(vref) - SW'(y_in);
        pterm_d = SW'($signed({1'b0, kp})) * err_d;
        iterm_d = SW'($signed({1'b0, ki})) * err_d;
        ibase_d = s_q.run ? s_q.integ : ($signed(SW'({1'b0, ss_init})) <<< GF);
        isum_d  = ibase_d + iterm_d;
        iclp_d  = clamp_int(isum_d);
        usum_d  = (iclp_d + pterm_d) >>> GF;
        uclp_d  = clamp_cmd(usum_d);
        rbase_d = s_q.run ? s_q.ramp : ss_init;
        rsum_d  = {1'b0, rbase_d} + {1'b0, ss_step};
        rnext_d = rsum_d[CW] ? '1 : rsum_d[CW-1:0];
        cross_d = (y_in >= thr);

        s_d = s_q;
        if (!en) begin
            s_d = '0;
        end else if (upd) begin
            s_d.run = 1'b1;
            if (s_q.rdy || cross_d) begin
                s_d.rdy   = 1'b1;
                s_d.integ = iclp_d;
                s_d.cmd   = uclp_d;
            end else begin
                s_d.ramp  = rnext_d;
                s_d.cmd   = rnext_d;
                s_d.integ = $signed(SW'({1'b0, rnext_d})) <<< GF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd   = s_q.cmd;
    assign ready = s_q.rdy;

    // R2: command only moves on a loop update
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !upd) |=> $stable(cmd));
    // R5: during soft-start the command never falls
    a_r5_ramp_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (en && upd && !ready && !cross_d) |=> (cmd >= $past(cmd)));
    // R6: reaching the threshold raises ready
    a_r6_ready_on_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (en && upd && cross_d) |=> ready);
    // R8: ready is sticky while enabled
    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ready) |=> ready);
    // R9: disable clears the output state
    a_r9_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!ready && cmd == '0));
endmodule

// File: rtl/vloop_top.sv
module vloop_top #(
    parameter int DW  = 16,
    parameter int CFW = 16,
    parameter int CFF = 14,
    parameter int GW  = 16,
    parameter int GF  = 8,
    parameter int CW  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  smp_stb,
    input  logic signed [DW-1:0]  smp_val,
    input  logic signed [DW-1:0]  vref,
    input  logic signed [CFW-1:0] cf_b0,
    input  logic signed [CFW-1:0] cf_b1,
    input  logic signed [CFW-1:0] cf_b2,
    input  logic signed [CFW-1:0] cf_a1,
    input  logic signed [CFW-1:0] cf_a2,
    input  logic [GW-1:0]         kp,
    input  logic [GW-1:0]         ki,
    input  logic [CW-1:0]         ss_init,
    input  logic [CW-1:0]         ss_step,
    output logic [CW-1:0]         cmd,
    output logic                  ready
);
    localparam int TW = DW + vloop_pkg::TH_BITS;

    logic signed [DW-1:0] filt_y;
    logic                 filt_vld;
    logic signed [DW-1:0] thr_d;

    function automatic logic signed [DW-1:0] scale_thr(input logic signed [DW-1:0] r);
        logic signed [TW-1:0] full;
        full = (TW'(r) * TW'($signed({1'b0, vloop_pkg::TH_NUM}))) >>> vloop_pkg::TH_SH;
        return full[DW-1:0];
    endfunction

    always_comb thr_d = scale_thr(vref);

    vloop_biquad #(.DW(DW), .CFW(CFW), .CFF(CFF)) u_notch (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (enable),
        .in_stb  (smp_stb),
        .in_x    (smp_val),
        .c_b0    (cf_b0),
        .c_b1    (cf_b1),
        .c_b2    (cf_b2),
        .c_a1    (cf_a1),
        .c_a2    (cf_a2),
        .out_vld (filt_vld),
        .out_y   (filt_y)
    );

    vloop_pi_ss #(.DW(DW), .GW(GW), .CW(CW), .GF(GF)) u_pi (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (enable),
        .upd     (filt_vld),
        .y_in    (filt_y),
        .vref    (vref),
        .thr     (thr_d),
        .kp      (kp),
        .ki      (ki),
        .ss_init (ss_init),
        .ss_step (ss_step),
        .cmd     (cmd),
        .ready   (ready)
    );

    // R1: outputs idle while the loop is not enabled
    a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (cmd == '0 && !ready));
endmodule

// File: tb/vloop_top_bench.sv
module vloop_top_bench;
    localparam int DW = 16, CFW = 16, CW = 12, GW = 16;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, smp_stb = 1'b0;
    logic signed [DW-1:0]  smp_val = '0, vref = '0;
    logic signed [CFW-1:0] b0 = '0, b1 = '0, b2 = '0, a1 = '0, a2 = '0;
    logic [GW-1:0] kp = '0, ki = '0;
    logic [CW-1:0] ss_init = '0, ss_step = '0;
    logic [CW-1:0] cmd;
    logic          ready;

    int    n_chk = 0, n_err = 0, cyc = 0;
    bit    cmp_on = 1'b0;
    string cur_tag = "R1";

    vloop_top u_vloop_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_stb(smp_stb), .smp_val(smp_val),
        .vref(vref), .cf_b0(b0), .cf_b1(b1), .cf_b2(b2), .cf_a1(a1), .cf_a2(a2),
        .kp(kp), .ki(ki), .ss_init(ss_init), .ss_step(ss_step), .cmd(cmd), .ready(ready)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    longint hx1, hx2, hy1, hy2, m_integ, m_ramp, m_cmd, pend_y;
    bit     m_run, m_ready, m_pend;

    task automatic model_clear();
        hx1 = 0; hx2 = 0; hy1 = 0; hy2 = 0;
        m_integ = 0; m_ramp = 0; m_cmd = 0; pend_y = 0;
        m_run = 0; m_ready = 0; m_pend = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || !enable) begin
            model_clear();
        end else begin
            if (m_pend) begin
                longint e, thr, base, isum, u;
                thr = (longint'(vref) * 973) >>> 10;
                e   = longint'(vref) - pend_y;
                if (m_ready || pend_y >= thr) begin
                    base = m_run ? m_integ : longint'(ss_init) * 256;
                    isum = base + longint'(ki) * e;
                    if (isum < 0) isum = 0;
                    if (isum > 4095 * 256) isum = 4095 * 256;
                    m_integ = isum;
                    u = (isum + longint'(kp) * e) >>> 8;
                    if (u < 0) u = 0;
                    if (u > 4095) u = 4095;
                    m_cmd = u;
                    m_ready = 1;
                end else begin
                    base = m_run ? m_ramp : longint'(ss_init);
                    base = base + longint'(ss_step);
                    if (base > 4095) base = 4095;
                    m_ramp = base; m_cmd = base; m_integ = base * 256;
                end
                m_run = 1; m_pend = 0;
            end
            if (smp_stb) begin
                longint acc, y;
                acc = longint'(b0) * longint'(smp_val) + longint'(b1) * hx1 + longint'(b2) * hx2
                    - longint'(a1) * hy1 - longint'(a2) * hy2;
                y = acc >>> 14;
                if (y > 32767) y = 32767;
                if (y < -32768) y = -32768;
                hx2 = hx1; hx1 = longint'(smp_val); hy2 = hy1; hy1 = y;
                pend_y = y; m_pend = 1;
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk({cur_tag, " cmd vs model"}, longint'(cmd), m_cmd);
            chk({cur_tag, " ready vs model"}, longint'(ready), longint'(m_ready));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            summary();
            $finish;
        end
    end

    // strobe at N0, notch at E0, PI at E1, result visible at N2
    task automatic strobe(input int x);
        longint c0;
        @(negedge clk);
        c0 = longint'(cmd);
        smp_stb = 1'b1; smp_val = 16'(x);
        @(negedge clk);
        smp_stb = 1'b0;
        if (enable) chk("R2 cmd held one edge after strobe", longint'(cmd), c0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        b0 = 16384; vref = 20000; kp = 256; ki = 64; ss_init = 100; ss_step = 50;
        repeat (3) @(negedge clk);
        chk("R1 cmd in reset", longint'(cmd), 0);
        chk("R1 ready in reset", longint'(ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        @(negedge clk);
        chk("R1 cmd while disabled", longint'(cmd), 0);
        enable = 1'b1;

        cur_tag = "R5";
        strobe(10000);
        chk("R5 first ramp step", longint'(cmd), 150);
        repeat (4) strobe(12000);
        chk("R5 ramp after five updates", longint'(cmd), 350);
        chk("R5 not ready during ramp", longint'(ready), 0);

        cur_tag = "R4";
        strobe(19002);
        chk("R4 one code below threshold", longint'(ready), 0);
        chk("R4 ramp continues", longint'(cmd), 400);

        cur_tag = "R6";
        strobe(19003);
        chk("R6 ready at threshold", longint'(ready), 1);
        chk("R6 seeded hand-over value", longint'(cmd), 1646);

        cur_tag = "R7";
        strobe(20000);
        chk("R7 zero error keeps integrator", longint'(cmd), 649);
        strobe(25000);
        chk("R7 clamp at zero", longint'(cmd), 0);
        strobe(-20000);
        chk("R7 clamp at full scale", longint'(cmd), 4095);
        strobe(20000);
        chk("R7 integrator clamped high", longint'(cmd), 4095);
        strobe(19500);
        strobe(20300);
        strobe(20700);

        cur_tag = "R8";
        strobe(5000);
        chk("R8 ready stays after low sample", longint'(ready), 1);

        cur_tag = "R9";
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 cmd cleared", longint'(cmd), 0);
        chk("R9 ready cleared", longint'(ready), 0);
        @(negedge clk);
        enable = 1'b1;
        strobe(10000);
        chk("R9 ramp restarts from init", longint'(cmd), 150);
        chk("R9 not ready after restart", longint'(ready), 0);

        cur_tag = "R3";
        enable = 1'b0;
        b0 = 16384; b1 = -32256; b2 = 16384; a1 = -30643; a2 = 14787;
        ss_step = 200;
        @(negedge clk);
        enable = 1'b1;
        for (int n = 0; n < 80; n++) begin
            real ph;
            ph = 2.0 * 3.14159265 * 100.0 * n / 3550.0;
            strobe(20000 + int'(3000.0 * $cos(ph)));
        end
        enable = 1'b0;
        b0 = 32767; b1 = 0; b2 = 0; a1 = 0; a2 = 0;
        @(negedge clk);
        enable = 1'b1;
        strobe(30000);
        chk("R3 positive saturation reaches threshold", longint'(ready), 1);
        strobe(-30000);
        chk("R3 negative saturation drives full scale", longint'(cmd), 4095);
        strobe(1000);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule